// File: doc/BRIEF.md
# Stream stall watchdog timer

This block guards the outgoing stream of a memory-to-stream DMA channel. When the channel still has words to send but the downstream sink refuses them, the block arms a one-shot down-counter. The counter is clocked by a tick that comes from a programmable prescaler, so it decrements once every `presc_val + 1` clock cycles. If the stall lasts for `tmo_count` ticks, the block emits a single-cycle timeout event, which a separate flag register elsewhere in the channel records.

As soon as the sink becomes ready, the timer stops, and any stall that follows starts a fresh count. After an expiry the timer stays idle until the sink has accepted data again. It never reloads by itself. The enable is tested again at the moment of expiry, so clearing it while the timer runs suppresses the event. Software normally programs the prescaler to 0xFFF and the count to 0xFFE after reset. Here both arrive as plain inputs.

Top module: `stall_tmo_timer`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `tmo_event` is 0.
- R2: The timer arms only on a clock edge where `tmo_en`=1, `work_left`=1 and `sink_ready`=0 all hold. A stall with `tmo_en`=0 or with `work_left`=0 never produces an event.
- R3: With prescaler value P and count T sampled at arming, `tmo_event` is high in the cycle that follows the clock edge T*(P+1) edges after the arming edge. A count of 0 behaves like 1.
- R4: `tmo_event` lasts exactly one cycle. While the stall continues after an expiry, no further event occurs.
- R5: Any edge with `sink_ready`=1 stops the timer and produces no event on that edge. A later stall restarts from the full count.
- R6: If `tmo_en` is 0 on the expiry edge, no event is produced, and the expired timer does not re-arm while the stall persists.
- R7: Arming resets the prescaler phase, so the first tick after a re-arm comes a full P+1 edges later.
- R8: Changes to `presc_val` or `tmo_count` while the timer runs do not affect the current countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_en | input | 1 | Timeout enable |
| presc_val | input | 12 | Prescaler value. The tick period is this value plus one clocks |
| tmo_count | input | 12 | Timeout length in ticks |
| work_left | input | 1 | The channel still has a nonzero remaining size |
| sink_ready | input | 1 | The stream sink accepts data |
| tmo_event | output | 1 | One-cycle stall timeout event |

## Verification
The hardest case to reach is a stall that is broken and resumed partway through a count. To detect a missing reload or a missing prescaler-phase reset, the bench must release `sink_ready` for a single cycle in the middle of a countdown and then measure the delay of the new arming exactly. Suppressing the event through the enable needs equally careful stimulus. The bench drops `tmo_en` after arming but before the expiry edge, and then raises it again while the stall persists, to show that the spent timer stays silent.

// File: rtl/stall_tmo_pkg.sv
package stall_tmo_pkg;
  localparam int unsigned FIELD_W = 12;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SPENT = 2'd2
  } tmo_state_e;
endpackage

// File: rtl/stall_tmo_ctrl.sv
module stall_tmo_ctrl
  import stall_tmo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic arm_ok,
  input  logic sink_ready,
  input  logic expire,
  output logic start,
  output logic running
);
  tmo_state_e state_q;

  assign start   = (state_q == ST_IDLE) && arm_ok;
  assign running = (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else if (sink_ready) begin
      state_q <= ST_IDLE;
    end else if (start) begin
      state_q <= ST_RUN;
    end else if (running && expire) begin
      state_q <= ST_SPENT;
    end
  end
endmodule

// File: rtl/stall_tmo_presc.sv
module stall_tmo_presc #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         running,
  input  logic [W-1:0] limit_in,
  output logic         tick
);
  logic [W-1:0] phase_q;
  logic [W-1:0] limit_q;

  assign tick = running && (phase_q == limit_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      limit_q <= '0;
    end else if (start) begin
      phase_q <= '0;
      limit_q <= limit_in;
    end else if (running) begin
      phase_q <= (phase_q == limit_q) ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/stall_tmo_cnt.sv
module stall_tmo_cnt #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         tick,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  assign expire = tick && (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/stall_tmo_timer.sv
module stall_tmo_timer
  import stall_tmo_pkg::*;
#(
  parameter int unsigned W = FIELD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tmo_en,
  input  logic [W-1:0] presc_val,
  input  logic [W-1:0] tmo_count,
  input  logic         work_left,
  input  logic         sink_ready,
  output logic         tmo_event
);
  logic arm_ok, start, run_q, tick, expire;

  assign arm_ok = tmo_en && work_left && !sink_ready;

  stall_tmo_ctrl u_ctrl (
    .clk(clk), .rst(rst), .arm_ok(arm_ok), .sink_ready(sink_ready),
    .expire(expire), .start(start), .running(run_q)
  );

  stall_tmo_presc #(.W(W)) u_presc (
    .clk(clk), .rst(rst), .start(start), .running(run_q),
    .limit_in(presc_val), .tick(tick)
  );

  stall_tmo_cnt #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .tick(tick),
    .load_val(tmo_count), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) tmo_event <= 1'b0;
    else     tmo_event <= expire && tmo_en && !sink_ready;
  end
endmodule

// File: rtl/stall_tmo_chk.sv
module stall_tmo_chk (
  input logic clk,
  input logic rst,
  input logic tmo_en,
  input logic work_left,
  input logic sink_ready,
  input logic tmo_event,
  input logic run_q
);
  AST_EVENT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tmo_event |=> !tmo_event); // R4
  AST_SPENT_NOT_RUNNING: assert property (@(posedge clk) disable iff (rst)
    tmo_event |-> !run_q); // R4
  AST_ARM_CONDITIONS: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> $past(tmo_en && work_left && !sink_ready)); // R2
  AST_READY_BLOCKS_EVENT: assert property (@(posedge clk) disable iff (rst)
    tmo_event |-> !$past(sink_ready)); // R5
  AST_ENABLE_AT_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    tmo_event |-> $past(tmo_en)); // R6
endmodule

bind stall_tmo_timer stall_tmo_chk u_chk (
  .clk(clk), .rst(rst), .tmo_en(tmo_en), .work_left(work_left),
  .sink_ready(sink_ready), .tmo_event(tmo_event), .run_q(run_q)
);

// File: tb/stall_tmo_timer_test.sv
module stall_tmo_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // presc, count, expected edges from stall drive to visible event
  localparam int VEC [NVEC][3] = '{
    '{0, 1, 2}, '{0, 5, 6}, '{2, 3, 10}, '{3, 0, 5}, '{1, 4, 9}
  };

  logic clk = 0, rst = 1, tmo_en = 0, work_left = 0, sink_ready = 1;
  logic [11:0] presc_val = 0, tmo_count = 0;
  logic tmo_event;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stall_tmo_timer uut (
    .clk(clk), .rst(rst), .tmo_en(tmo_en), .presc_val(presc_val),
    .tmo_count(tmo_count), .work_left(work_left), .sink_ready(sink_ready),
    .tmo_event(tmo_event)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; sink_ready = 1; tmo_en = 0; work_left = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  // returns number of edges until tmo_event seen high, 0 if never
  task automatic measure(input int maxc, output int n);
    n = 0;
    for (int i = 1; i <= maxc; i++) begin
      @(posedge clk); @(negedge clk);
      if (tmo_event) begin n = i; return; end
    end
  endtask

  task automatic quiet(input int cyc, output int seen);
    seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk); @(negedge clk);
      if (tmo_event) seen = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n, s;
    do_reset();
    check("R1 event low after reset", tmo_event, 0);

    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      presc_val = VEC[v][0]; tmo_count = VEC[v][1];
      tmo_en = 1; work_left = 1; sink_ready = 0;
      measure(64, n);
      check("R3 expiry delay", n, VEC[v][2]);
      @(posedge clk); @(negedge clk);
      check("R4 single-cycle event", tmo_event, 0);
      quiet(3 * VEC[v][2] + 4, s);
      check("R4 no reload while stalled", s, 0);
    end

    // R2: enable clear
    do_reset();
    presc_val = 0; tmo_count = 2; tmo_en = 0; work_left = 1; sink_ready = 0;
    quiet(20, s);
    check("R2 no event with enable low", s, 0);
    // R2: no work left
    do_reset();
    tmo_en = 1; work_left = 0; sink_ready = 0;
    quiet(20, s);
    check("R2 no event with no work", s, 0);

    // R5: ready mid-count stops and restarts full count
    do_reset();
    presc_val = 0; tmo_count = 6; tmo_en = 1; work_left = 1; sink_ready = 0;
    quiet(4, s);
    sink_ready = 1;
    @(negedge clk);
    sink_ready = 0;
    measure(40, n);
    check("R5 re-arm from full count", n, 7);
    check("R5 no early event", s, 0);

    // R7: prescaler phase reset on re-arm
    do_reset();
    presc_val = 3; tmo_count = 2; tmo_en = 1; work_left = 1; sink_ready = 0;
    quiet(6, s);
    sink_ready = 1;
    @(negedge clk);
    sink_ready = 0;
    measure(40, n);
    check("R7 phase restart", n, 9);

    // R6: enable dropped before expiry
    do_reset();
    presc_val = 0; tmo_count = 4; tmo_en = 1; work_left = 1; sink_ready = 0;
    quiet(2, s);
    tmo_en = 0;
    quiet(6, n);
    check("R6 no event with enable low at expiry", n, 0);
    tmo_en = 1;
    quiet(20, s);
    check("R6 spent timer stays silent", s, 0);

    // R8: settings changed while running
    do_reset();
    presc_val = 0; tmo_count = 5; tmo_en = 1; work_left = 1; sink_ready = 0;
    @(posedge clk); @(negedge clk);
    presc_val = 3; tmo_count = 1;
    measure(40, n);
    check("R8 settings held at arming", n + 1, 6);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule